// File: doc/BRIEF.md
# Dual-Mode Asynchronous SRAM Front End

This block is a synthesizable stand-in for the control side of a 16-bit asynchronous static RAM that can also run as an 8-bit-wide part. It receives the raw memory pins as ordinary inputs:

- an active-low chip select and an active-high chip select;
- active-low write and output enables;
- two active-low byte-lane enables;
- an active-low byte-mode pin;
- the word address;
- a data bus split into separate input, output and output-enable vectors, so no real tri-state is needed.

A fast internal clock samples every pin through a configurable synchroniser. Each sample is decoded into one of four actions: deselect, write, read or output disable. The block keeps its contents in two internal byte-lane arrays.

In word mode the two lane enables pick which halves of the 16-bit word take part in an access. In byte mode only data bits 7:0 carry data and the lane enables have no effect. Data pin 15 then serves as an extra, least significant address bit that selects one half of the addressed word.

A write happens only while all of its qualifying conditions overlap. It is committed when the internal sample shows that overlap ending, using the pin values of the sample taken one cycle earlier. The array depth is a parameter: a full-size part has 524288 words, and a test setup can use a much smaller array.

Top module: `dual_mode_sram_front`

## Requirements
- R1: The block is deselected when `cs_act_n` is 1 or `cs_act` is 0. In word mode (`narrow_n`=1) it is also deselected when `lane_lo_n` and `lane_hi_n` are both 1. While deselected, `dq_oe` is all zero and no location is modified.
- R2: In word mode, `lane_lo_n`=0 enables bits 7:0 and `lane_hi_n`=0 enables bits 15:8. A read drives only the enabled lanes, and a write changes only the enabled lanes of the stored word. Either lane or both may take part in one access.
- R3: In byte mode (`narrow_n`=0), the lane enables are ignored and `dq_in[15]` is address bit -1. A value of 0 selects bits 7:0 of the addressed word and 1 selects bits 15:8. The data uses pins 7:0 only, `dq_in[14:8]` is ignored, and `dq_oe[15:8]` stays 0.
- R4: A write is committed when the overlap of both chip selects active, `we_n`=0 and at least one enabled lane ends. The data stored is the value sampled one internal cycle before the end, and lanes that were not enabled keep their contents.
- R5: While selected with `we_n`=0, the cycle is a write whatever the value of `oe_n`, and `dq_oe` stays all zero.
- R6: While selected with `we_n`=1 and `oe_n`=1 (output disable), `dq_oe` is all zero and nothing is written.
- R7: If the addressed word or the set of enabled lanes changes while the write overlap continues, the write to the previous location ends and is committed, and a new write begins at the new location.
- R8: The outputs respond to a pin change after `SYNC_STAGES`+1 rising clock edges. Every `dq_out` bit whose `dq_oe` bit is 0 reads as 0.
- R9: While `rst_n` is low and after its release, until a read is decoded, `dq_oe` and `dq_out` are zero.
- R10: The array holds `DEPTH` words. Byte mode reaches 2×`DEPTH` bytes, including the high byte of word `DEPTH`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_act_n | input | 1 | Active-low chip select |
| cs_act | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lane_lo_n | input | 1 | Active-low enable for data bits 7:0 (word mode) |
| lane_hi_n | input | 1 | Active-low enable for data bits 15:8 (word mode) |
| narrow_n | input | 1 | 0 selects byte mode, 1 selects word mode |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| dq_in | input | 16 | Data bus input side; bit 15 is address bit -1 in byte mode |
| dq_out | output | 16 | Data bus output side |
| dq_oe | output | 16 | Per-pin output enable for the data bus |

## Verification
The bench aims at byte mode with both lane enables inactive. A design that treated that as a deselect would leave the byte unwritten and the output floating. It also drives junk on data pins 14:8 during byte accesses and uses the highest byte of the array. A wrong address-bit mapping would then land data in the wrong half, and a leak of the upper pins would corrupt the stored word or raise upper output enables.

Writes are issued with the output enable held active and with single-lane masks. A design that let the output enable win, or wrote whole words, would drive the bus during the write or overwrite the neighbouring lane. Write attempts under each of the three deselect conditions are read back unchanged, and an address change in mid-write must commit both locations. A design that committed only at the write-enable edge, or that took the data of the closing sample, would lose or mix those values.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
   localparam int LANE_W = 8;
   localparam int LANES  = 2;
   localparam int BUS_W  = LANE_W * LANES;

   // one synchronised snapshot of the control pins
   typedef struct packed {
      logic sel_n;   // active-low select
      logic sel;     // active-high select
      logic wr_n;    // write enable
      logic rd_n;    // output enable
      logic lo_n;    // lane 0 enable
      logic hi_n;    // lane 1 enable
      logic wide;    // 1 = word mode
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1,
                                 lo_n: 1'b1, hi_n: 1'b1, wide: 1'b1};

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_HIZ   = 2'd1,
      OP_READ  = 2'd2,
      OP_WRITE = 2'd3
   } op_e;
endpackage

// File: rtl/sram_fe_sync.sv
module sram_fe_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 0 && STAGES <= 8) else $error("sram_fe_sync: STAGES out of range");
      assert (W >= 1) else $error("sram_fe_sync: W must be positive");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) st[s] <= RST;
         end else begin
            st[0] <= d;
            for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/sram_fe_decode.sv
module sram_fe_decode
   import sram_fe_pkg::*;
#(
   parameter int AW = 10
) (
   input  ctl_t              c,
   input  logic [AW-1:0]     addr,
   input  logic [BUS_W-1:0]  din,
   output op_e               op,
   output logic [LANES-1:0]  mask,
   output logic [AW-1:0]     word,
   output logic [BUS_W-1:0]  wdata,
   output logic              narrow,
   output logic              half
);
   always_comb begin
      narrow = ~c.wide;
      half   = narrow & din[BUS_W-1];
      if (narrow) mask = half ? 2'b10 : 2'b01;
      else        mask = {~c.hi_n, ~c.lo_n};
      // in byte mode the byte on pins 7:0 feeds whichever lane is chosen
      wdata = narrow ? {din[LANE_W-1:0], din[LANE_W-1:0]} : din;
      word  = addr;
      if (c.sel_n || !c.sel || mask == '0) op = OP_IDLE;
      else if (!c.wr_n)                    op = OP_WRITE;
      else if (!c.rd_n)                    op = OP_READ;
      else                                 op = OP_HIZ;
   end
endmodule

// File: rtl/sram_fe_lane.sv
module sram_fe_lane
   import sram_fe_pkg::*;
#(
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [LANE_W-1:0] rdata
);
   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sram_fe_drive.sv
module sram_fe_drive
   import sram_fe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op,
   input  logic [LANES-1:0]  mask,
   input  logic              narrow,
   input  logic              half,
   input  logic [LANE_W-1:0] rd_lo,
   input  logic [LANE_W-1:0] rd_hi,
   output logic [BUS_W-1:0]  dq_out,
   output logic [BUS_W-1:0]  dq_oe
);
   logic [BUS_W-1:0] nxt_oe, nxt_out;

   always_comb begin
      nxt_oe  = '0;
      nxt_out = '0;
      if (op == OP_READ) begin
         if (narrow) begin
            nxt_oe[LANE_W-1:0]  = '1;
            nxt_out[LANE_W-1:0] = half ? rd_hi : rd_lo;
         end else begin
            nxt_oe  = {{LANE_W{mask[1]}}, {LANE_W{mask[0]}}};
            nxt_out = {rd_hi, rd_lo} & nxt_oe;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_oe  <= '0;
         dq_out <= '0;
      end else begin
         dq_oe  <= nxt_oe;
         dq_out <= nxt_out;
      end
   end

   AST_BYTE_UPPER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |=> dq_oe[BUS_W-1:LANE_W] == '0);                                 // R3
   AST_HIZ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_HIZ |=> dq_oe == '0);                                           // R6
   AST_WORD_LANE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ && !narrow) |=> ($countones(dq_oe) == LANE_W || $countones(dq_oe) == BUS_W)); // R2
endmodule

// File: rtl/dual_mode_sram_front.sv
module dual_mode_sram_front
   import sram_fe_pkg::*;
#(
   parameter int  DEPTH       = 1024,
   parameter int  SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act_n,
   input  logic              cs_act,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              lane_lo_n,
   input  logic              lane_hi_n,
   input  logic              narrow_n,
   input  logic [AW-1:0]     addr,
   input  logic [BUS_W-1:0]  dq_in,
   output logic [BUS_W-1:0]  dq_out,
   output logic [BUS_W-1:0]  dq_oe
);
   localparam int CW = $bits(ctl_t);
   localparam int SW = CW + AW + BUS_W;
   localparam logic [SW-1:0] SYNC_RST = {CTL_IDLE, {AW{1'b0}}, {BUS_W{1'b0}}};

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH) else $error("DEPTH must be a power of two >= 2");
      assert (LANES == 2) else $error("two byte lanes expected");
   end

   // ---------------- pin sampling ----------------
   ctl_t             ctl_raw, ctl_s;
   logic [AW-1:0]    addr_s;
   logic [BUS_W-1:0] din_s;

   assign ctl_raw = '{sel_n: cs_act_n, sel: cs_act, wr_n: we_n, rd_n: oe_n,
                      lo_n: lane_lo_n, hi_n: lane_hi_n, wide: narrow_n};

   sram_fe_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ctl_raw, addr, dq_in}),
      .q     ({ctl_s, addr_s, din_s})
   );

   // ---------------- decode of the current sample ----------------
   op_e              cur_op;
   logic [LANES-1:0] cur_mask;
   logic [AW-1:0]    cur_word;
   logic [BUS_W-1:0] cur_wdata;
   logic             cur_narrow, cur_half;

   sram_fe_decode #(.AW(AW)) u_dec (
      .c      (ctl_s),
      .addr   (addr_s),
      .din    (din_s),
      .op     (cur_op),
      .mask   (cur_mask),
      .word   (cur_word),
      .wdata  (cur_wdata),
      .narrow (cur_narrow),
      .half   (cur_half)
   );

   // ---------------- previous sample, used for write commit ----------------
   op_e              prv_op;
   logic [LANES-1:0] prv_mask;
   logic [AW-1:0]    prv_word;
   logic [BUS_W-1:0] prv_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_op    <= OP_IDLE;
         prv_mask  <= '0;
         prv_word  <= '0;
         prv_wdata <= '0;
      end else begin
         prv_op    <= cur_op;
         prv_mask  <= cur_mask;
         prv_word  <= cur_word;
         prv_wdata <= cur_wdata;
      end
   end

   logic wr_end;
   assign wr_end = (prv_op == OP_WRITE) &&
                   (cur_op != OP_WRITE || cur_word != prv_word || cur_mask != prv_mask);

   // ---------------- byte-lane arrays ----------------
   logic [LANES-1:0][LANE_W-1:0] rd_lane;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sram_fe_lane #(.DEPTH(DEPTH)) u_lane (
         .clk   (clk),
         .we    (wr_end & prv_mask[i]),
         .waddr (prv_word),
         .wdata (prv_wdata[i*LANE_W +: LANE_W]),
         .raddr (cur_word),
         .rdata (rd_lane[i])
      );
   end

   // ---------------- output side ----------------
   sram_fe_drive u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (cur_op),
      .mask   (cur_mask),
      .narrow (cur_narrow),
      .half   (cur_half),
      .rd_lo  (rd_lane[0]),
      .rd_hi  (rd_lane[1]),
      .dq_out (dq_out),
      .dq_oe  (dq_oe)
   );

   AST_DESEL_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      cur_op == OP_IDLE |=> dq_oe == '0);                                      // R1
   AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_op == OP_WRITE |=> dq_oe == '0);                                     // R5
   AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_end |-> prv_mask != '0);                                              // R4
   AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_out & ~dq_oe) == '0);                                                // R8
endmodule

// File: tb/sim_dual_mode_sram_front.sv
`timescale 1ns/1ps
module sim_dual_mode_sram_front;
   localparam int DEPTH = 64;
   localparam int AW    = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_act_n, cs_act, we_n, oe_n, lane_lo_n, lane_hi_n, narrow_n;
   logic [AW-1:0] addr;
   logic [15:0] dq_in, dq_out, dq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] model [DEPTH];

   always #2.5 clk = ~clk;

   dual_mode_sram_front #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_act_n(cs_act_n), .cs_act(cs_act), .we_n(we_n),
      .oe_n(oe_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .narrow_n(narrow_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   function automatic logic [15:0] lane_pins(bit lo, bit hi);
      return {{8{hi}}, {8{lo}}};
   endfunction

   function automatic logic [7:0] model_byte(int a, bit half);
      return half ? model[a][15:8] : model[a][7:0];
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic settle(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_pins();
      cs_act_n = 1'b1; cs_act = 1'b0; we_n = 1'b1; oe_n = 1'b1;
      lane_lo_n = 1'b1; lane_hi_n = 1'b1; narrow_n = 1'b1; dq_in = '0;
   endtask

   task automatic select();
      cs_act_n = 1'b0; cs_act = 1'b1;
   endtask

   task automatic wr_word(int a, logic [15:0] d, bit lo, bit hi, bit oe_low);
      select(); narrow_n = 1'b1; addr = AW'(a); dq_in = d;
      lane_lo_n = ~lo; lane_hi_n = ~hi; oe_n = ~oe_low; we_n = 1'b0;
      settle(4);
      chk("R5 bus floats during write", dq_oe, 16'h0);
      we_n = 1'b1; oe_n = 1'b1;
      settle(4);
      if (lo) model[a][7:0]  = d[7:0];
      if (hi) model[a][15:8] = d[15:8];
      idle_pins(); settle(1);
   endtask

   task automatic rd_word(int a, bit lo, bit hi, string tag);
      logic [15:0] m;
      select(); narrow_n = 1'b1; addr = AW'(a); dq_in = 16'($urandom);
      lane_lo_n = ~lo; lane_hi_n = ~hi; we_n = 1'b1; oe_n = 1'b0;
      settle(4);
      m = lane_pins(lo, hi);
      chk({tag, " word oe"}, dq_oe, m);
      chk({tag, " word data"}, dq_out, model[a] & m);
      idle_pins(); settle(1);
   endtask

   task automatic wr_byte(int a, bit half, logic [7:0] d);
      select(); narrow_n = 1'b0; addr = AW'(a);
      dq_in = {half, 7'($urandom), d};          // pins 14:8 carry junk
      lane_lo_n = 1'($urandom); lane_hi_n = 1'($urandom);
      oe_n = 1'($urandom); we_n = 1'b0;
      settle(4);
      chk("R5 bus floats during byte write", dq_oe, 16'h0);
      we_n = 1'b1; oe_n = 1'b1;
      settle(4);
      if (half) model[a][15:8] = d; else model[a][7:0] = d;
      idle_pins(); settle(1);
   endtask

   task automatic rd_byte(int a, bit half, string tag);
      select(); narrow_n = 1'b0; addr = AW'(a);
      dq_in = {half, 15'($urandom)};
      lane_lo_n = 1'($urandom); lane_hi_n = 1'($urandom);
      we_n = 1'b1; oe_n = 1'b0;
      settle(4);
      chk({tag, " byte oe"}, dq_oe, 16'h00FF);
      chk({tag, " byte data"}, dq_out, {8'h00, model_byte(a, half)});
      idle_pins(); settle(1);
   endtask

   task automatic desel_write(int kind, int a, logic [15:0] d);
      cs_act_n = (kind == 0); cs_act = (kind != 1);
      narrow_n = 1'b1; addr = AW'(a); dq_in = d;
      lane_lo_n = (kind == 2); lane_hi_n = (kind == 2);
      oe_n = 1'b0; we_n = 1'b0;
      settle(4);
      chk("R1 deselected bus floats", dq_oe, 16'h0);
      we_n = 1'b1;
      settle(4);
      chk("R1 deselected read floats", dq_oe, 16'h0);
      idle_pins(); settle(1);
      rd_word(a, 1'b1, 1'b1, "R1 deselected write ignored");
   endtask

   task automatic out_disable(int a);
      select(); narrow_n = 1'b1; addr = AW'(a);
      lane_lo_n = 1'b0; lane_hi_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
      settle(4);
      chk("R6 output disable floats", dq_oe, 16'h0);
      chk("R8 undriven data is zero", dq_out, 16'h0);
      idle_pins(); settle(1);
      rd_word(a, 1'b1, 1'b1, "R6 nothing written");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd13579));
      idle_pins(); addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 reset oe", dq_oe, 16'h0);
      chk("R9 reset data", dq_out, 16'h0);
      rst_n = 1'b1;
      settle(3);
      chk("R9 after release oe", dq_oe, 16'h0);
      chk("R9 after release data", dq_out, 16'h0);

      // fill the array so every read has a defined expectation
      for (int a = 0; a < DEPTH; a++) wr_word(a, 16'($urandom), 1'b1, 1'b1, a[0]);
      rd_word(5, 1'b1, 1'b1, "R4 word write readback");

      // R2 single-lane accesses
      wr_word(7, 16'hA55A, 1'b1, 1'b0, 1'b0);
      rd_word(7, 1'b1, 1'b1, "R2 low lane only written");
      wr_word(7, 16'h3CC3, 1'b0, 1'b1, 1'b1);
      rd_word(7, 1'b1, 1'b1, "R2 high lane only written");
      rd_word(7, 1'b0, 1'b1, "R2 high lane read");
      rd_word(7, 1'b1, 1'b0, "R2 low lane read");

      // R3 byte mode, both halves, lane pins ignored
      wr_byte(9, 1'b0, 8'h11);
      wr_byte(9, 1'b1, 8'hEE);
      rd_word(9, 1'b1, 1'b1, "R3 byte halves into word");
      rd_byte(9, 1'b1, "R3 high half");
      rd_byte(9, 1'b0, "R3 low half");

      // R10 top byte of the array
      wr_byte(DEPTH - 1, 1'b1, 8'h5F);
      rd_byte(DEPTH - 1, 1'b1, "R10 last byte");
      rd_word(DEPTH - 1, 1'b1, 1'b1, "R10 last word");

      // R1 three deselect conditions
      desel_write(0, 12, 16'hDEAD);
      desel_write(1, 13, 16'hBEEF);
      desel_write(2, 14, 16'hF00D);

      // R6 output disable
      out_disable(15);

      // R7 address change during an ongoing write
      select(); narrow_n = 1'b1; lane_lo_n = 1'b0; lane_hi_n = 1'b0; oe_n = 1'b1;
      addr = AW'(20); dq_in = 16'h1234; we_n = 1'b0;
      settle(4);
      addr = AW'(21); dq_in = 16'h5678;
      settle(4);
      we_n = 1'b1;
      settle(4);
      model[20] = 16'h1234; model[21] = 16'h5678;
      idle_pins(); settle(1);
      rd_word(20, 1'b1, 1'b1, "R7 first location kept");
      rd_word(21, 1'b1, 1'b1, "R7 second location kept");

      // R8 response latency: SYNC_STAGES+1 edges
      select(); narrow_n = 1'b1; addr = AW'(21);
      lane_lo_n = 1'b0; lane_hi_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R8 not yet driven", dq_oe, 16'h0);
      @(posedge clk);
      @(negedge clk);
      chk("R8 driven on third edge", dq_oe, 16'hFFFF);
      chk("R8 data on third edge", dq_out, 16'h5678);
      idle_pins(); settle(1);

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         int a;
         int k;
         a = int'($urandom % DEPTH);
         k = int'($urandom % 7);
         case (k)
            0: wr_word(a, 16'($urandom), 1'($urandom), 1'b1, 1'($urandom));
            1: wr_word(a, 16'($urandom), 1'b1, 1'($urandom), 1'($urandom));
            2: rd_word(a, 1'($urandom), 1'b1, "R2 random word");
            3: wr_byte(a, 1'($urandom), 8'($urandom));
            4: rd_byte(a, 1'($urandom), "R3 random byte");
            5: desel_write(int'($urandom % 3), a, 16'($urandom));
            default: out_disable(a);
         endcase
      end

      finish_run();
   end
endmodule